// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block derives horizontal and vertical raster timing from a set of compare values that software writes. A horizontal counter runs from zero up to a programmed period. Each line end advances a vertical counter that counts half-lines. Window compares on the two counts produce a display-enable, a border-enable and two sync pulses. Each sync pulse has its own polarity bit. A line strobe and a frame strobe mark the counter wraps.

Software writes settings through a single-cycle write port into a shadow set. The shadow set moves into the working set only at a frame wrap, so a frame never mixes old and new timing. The vertical period is not written directly. A rate bit picks one of two preset periods, which are given as parameters. Double scan halves the vertical step. Interlace alternates a field flag, and in odd fields it moves the vsync leading edge half a line later. A flag on the display-begin value moves the start of active display into the second half of the line.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal count runs 0,1,...,HPER and then returns to 0. `line_stb` is high exactly in the cycle where the count equals HPER.
- R2: The vertical count starts at 0 and adds 2 at each line end, or 1 when double scan (control bit 3) is set. When the next value would exceed the vertical period, the count returns to 0. The vertical period is VPER_60 when control bit 4 is 0 and VPER_50 when it is 1. `frame_stb` is high in the last cycle of the final line of a frame, and only together with `line_stb`.
- R3: `disp_en` is high when the horizontal count H satisfies HDBeff <= H < HDE and the vertical count V satisfies VDB <= V < VDE. HDBeff is HDB plus (HPER+1)/2 (integer division) when bit 9 of the HDB register is 1, and HDB alone otherwise.
- R4: `border_en` is high when HBB <= H < HBE and VBB <= V < VBE, and `disp_en` is low. The two enables are never high together.
- R5: The horizontal sync is active while H >= HSS. `hsync` equals the active state when control bit 0 is 1 and its inverse when bit 0 is 0. The vertical sync is active while V >= VSS, and control bit 1 sets the polarity of `vsync` in the same way.
- R6: `field_odd` toggles at every frame wrap and holds otherwise. When interlace (control bit 2) is set and `field_odd` is 1, vertical sync becomes active only when V > VSS, or when V = VSS and H >= (HPER+1)/2.
- R7: A write lands in the shadow set. The working set takes the shadow set only at the clock edge that ends a frame. A write made during a frame changes nothing until that frame has ended.
- R8: After reset every setting is zero. As a result `line_stb` is high every cycle and `disp_en`, `border_en` and `hsync` are low.
- R9: The register addresses are HPER=0, HBB=1, HBE=2, HDB=3, HDE=4, HSS=5, VBB=6, VBE=7, VDB=8, VDE=9, VSS=10 and CTRL=11. Horizontal values sit in bits 8:0. The HDB half-line flag is bit 9. Vertical values sit in bits 10:0. CTRL uses bits 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_addr | input | 4 | Setting address |
| wr_data | input | 16 | Setting value |
| hsync | output | 1 | Horizontal sync, polarity set by software |
| vsync | output | 1 | Vertical sync, polarity set by software |
| disp_en | output | 1 | Active display window |
| border_en | output | 1 | Border window outside the display |
| line_stb | output | 1 | Last cycle of each line |
| frame_stb | output | 1 | Last cycle of each frame |
| field_odd | output | 1 | Field parity, toggles every frame |

## Verification
The bench predicts every output in every cycle of whole frames from the cycle index alone. It does this for three settings: plain single-step lines, an odd horizontal period, and double scan with interlace, the half-line display flag and inverted polarities. A design with an off-by-one wrap would put `frame_stb` or the sync edges a line early or late. A design that ignored the half-line flag, or the half-line vsync delay in odd fields, would raise `disp_en` or `vsync` half a line early. The bench writes the horizontal period in mid-frame, which catches a design that applies writes at once: that frame would lose step with the prediction. Two consecutive interlaced frames expose a field flag that fails to alternate.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int RT_HW = 9;
    localparam int RT_VW = 11;
    localparam int RT_AW = 4;
    localparam int RT_DW = 16;

    typedef enum logic [RT_AW-1:0] {
        RA_HPER = 4'd0,
        RA_HBB  = 4'd1,
        RA_HBE  = 4'd2,
        RA_HDB  = 4'd3,
        RA_HDE  = 4'd4,
        RA_HSS  = 4'd5,
        RA_VBB  = 4'd6,
        RA_VBE  = 4'd7,
        RA_VDB  = 4'd8,
        RA_VDE  = 4'd9,
        RA_VSS  = 4'd10,
        RA_CTRL = 4'd11
    } rt_addr_e;

    typedef struct packed {
        logic [RT_HW-1:0] hper;
        logic [RT_HW-1:0] hbb;
        logic [RT_HW-1:0] hbe;
        logic [RT_HW-1:0] hdb;
        logic             hdb_half;
        logic [RT_HW-1:0] hde;
        logic [RT_HW-1:0] hss;
        logic [RT_VW-1:0] vbb;
        logic [RT_VW-1:0] vbe;
        logic [RT_VW-1:0] vdb;
        logic [RT_VW-1:0] vde;
        logic [RT_VW-1:0] vss;
        logic             hpol;
        logic             vpol;
        logic             ilace;
        logic             dscan;
        logic             rate50;
    } rt_cfg_t;

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RT_AW-1:0] wr_addr,
    input  logic [RT_DW-1:0] wr_data,
    input  logic             frame_load,
    output rt_cfg_t          cfg
);

    typedef struct packed {
        rt_cfg_t shadow;
        rt_cfg_t active;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (rt_addr_e'(wr_addr))
                RA_HPER: s_d.shadow.hper = wr_data[RT_HW-1:0];
                RA_HBB:  s_d.shadow.hbb  = wr_data[RT_HW-1:0];
                RA_HBE:  s_d.shadow.hbe  = wr_data[RT_HW-1:0];
                RA_HDB: begin
                    s_d.shadow.hdb      = wr_data[RT_HW-1:0];
                    s_d.shadow.hdb_half = wr_data[RT_HW];
                end
                RA_HDE:  s_d.shadow.hde  = wr_data[RT_HW-1:0];
                RA_HSS:  s_d.shadow.hss  = wr_data[RT_HW-1:0];
                RA_VBB:  s_d.shadow.vbb  = wr_data[RT_VW-1:0];
                RA_VBE:  s_d.shadow.vbe  = wr_data[RT_VW-1:0];
                RA_VDB:  s_d.shadow.vdb  = wr_data[RT_VW-1:0];
                RA_VDE:  s_d.shadow.vde  = wr_data[RT_VW-1:0];
                RA_VSS:  s_d.shadow.vss  = wr_data[RT_VW-1:0];
                RA_CTRL: begin
                    s_d.shadow.hpol   = wr_data[0];
                    s_d.shadow.vpol   = wr_data[1];
                    s_d.shadow.ilace  = wr_data[2];
                    s_d.shadow.dscan  = wr_data[3];
                    s_d.shadow.rate50 = wr_data[4];
                end
                default: ;
            endcase
        end
        if (frame_load) s_d.active = s_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg = s_q.active;

endmodule

// File: rtl/raster_hcount.sv
module raster_hcount
    import raster_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rt_cfg_t cfg,
    output logic    line_end,
    output logic    h_late,
    output logic    h_disp,
    output logic    h_bord,
    output logic    h_sync
);

    typedef struct packed {
        logic [RT_HW-1:0] hcnt;
    } hst_t;

    hst_t s_d, s_q;
    logic [RT_HW:0] half;
    logic [RT_HW:0] hdb_eff;
    logic [RT_HW:0] h_ext;

    always_comb begin
        s_d      = s_q;
        h_ext    = {1'b0, s_q.hcnt};
        half     = ({1'b0, cfg.hper} + 1'b1) >> 1;
        hdb_eff  = {1'b0, cfg.hdb} + (cfg.hdb_half ? half : '0);
        line_end = (s_q.hcnt == cfg.hper);
        s_d.hcnt = line_end ? '0 : s_q.hcnt + 1'b1;
        h_late   = (h_ext >= half);
        h_disp   = (h_ext >= hdb_eff) && (s_q.hcnt < cfg.hde);
        h_bord   = (s_q.hcnt >= cfg.hbb) && (s_q.hcnt < cfg.hbe);
        h_sync   = (s_q.hcnt >= cfg.hss);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
    import raster_pkg::*;
#(
    parameter int VPER_60 = 1049,
    parameter int VPER_50 = 1249
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rt_cfg_t cfg,
    input  logic    line_end,
    input  logic    h_late,
    output logic    frame_end,
    output logic    field_odd,
    output logic    v_disp,
    output logic    v_bord,
    output logic    v_sync
);

    localparam logic [RT_VW-1:0] P60 = RT_VW'(VPER_60);
    localparam logic [RT_VW-1:0] P50 = RT_VW'(VPER_50);
    localparam logic [RT_VW:0]   STEP1 = 1;
    localparam logic [RT_VW:0]   STEP2 = 2;

    typedef struct packed {
        logic [RT_VW-1:0] vcnt;
        logic             field;
    } vst_t;

    vst_t s_d, s_q;
    logic [RT_VW-1:0] vper;
    logic [RT_VW:0]   nxt;

    always_comb begin
        s_d       = s_q;
        vper      = cfg.rate50 ? P50 : P60;
        nxt       = {1'b0, s_q.vcnt} + (cfg.dscan ? STEP1 : STEP2);
        frame_end = line_end && (nxt > {1'b0, vper});
        if (line_end) s_d.vcnt = frame_end ? '0 : nxt[RT_VW-1:0];
        if (frame_end) s_d.field = ~s_q.field;
        field_odd = s_q.field;
        v_disp    = (s_q.vcnt >= cfg.vdb) && (s_q.vcnt < cfg.vde);
        v_bord    = (s_q.vcnt >= cfg.vbb) && (s_q.vcnt < cfg.vbe);
        if (cfg.ilace && s_q.field)
            v_sync = (s_q.vcnt > cfg.vss) || ((s_q.vcnt == cfg.vss) && h_late);
        else
            v_sync = (s_q.vcnt >= cfg.vss);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int VPER_60 = 1049,
    parameter int VPER_50 = 1249
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RT_AW-1:0] wr_addr,
    input  logic [RT_DW-1:0] wr_data,
    output logic             hsync,
    output logic             vsync,
    output logic             disp_en,
    output logic             border_en,
    output logic             line_stb,
    output logic             frame_stb,
    output logic             field_odd
);

    rt_cfg_t active_cfg;
    logic    line_end, h_late, h_disp, h_bord, h_sync;
    logic    frame_end, v_disp, v_bord, v_sync;

    raster_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_load (frame_end),
        .cfg        (active_cfg)
    );

    raster_hcount u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (active_cfg),
        .line_end (line_end),
        .h_late   (h_late),
        .h_disp   (h_disp),
        .h_bord   (h_bord),
        .h_sync   (h_sync)
    );

    raster_vcount #(
        .VPER_60 (VPER_60),
        .VPER_50 (VPER_50)
    ) u_vcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (active_cfg),
        .line_end  (line_end),
        .h_late    (h_late),
        .frame_end (frame_end),
        .field_odd (field_odd),
        .v_disp    (v_disp),
        .v_bord    (v_bord),
        .v_sync    (v_sync)
    );

    always_comb begin
        disp_en   = h_disp && v_disp;
        border_en = h_bord && v_bord && !disp_en;
        hsync     = active_cfg.hpol ? h_sync : !h_sync;
        vsync     = active_cfg.vpol ? v_sync : !v_sync;
        line_stb  = line_end;
        frame_stb = frame_end;
    end

endmodule

// File: rtl/raster_checker.sv
module raster_checker
    import raster_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    line_stb,
    input logic    frame_stb,
    input logic    field_odd,
    input logic    disp_en,
    input logic    border_en,
    input rt_cfg_t cfg
);

    p_frame_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> line_stb)
        else $error("frame strobe outside a line end");

    p_disp_border_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_en && border_en))
        else $error("display and border both enabled");

    p_field_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (field_odd != $past(field_odd)))
        else $error("field did not toggle at frame wrap");

    p_field_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(field_odd))
        else $error("field changed inside a frame");

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(cfg))
        else $error("working settings changed inside a frame");

endmodule

bind raster_timing_gen raster_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_stb  (line_stb),
    .frame_stb (frame_stb),
    .field_odd (field_odd),
    .disp_en   (disp_en),
    .border_en (border_en),
    .cfg       (active_cfg)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;

    localparam int P60 = 39;
    localparam int P50 = 49;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic hsync, vsync, disp_en, border_en, line_stb, frame_stb, field_odd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int eH, ehbb, ehbe, ehdb, ehalf_flag, ehde, ehss;
    int evbb, evbe, evdb, evde, evss;
    int ehpol, evpol, eil, eds, er50;

    always #2.5 clk = ~clk;

    raster_timing_gen #(.VPER_60(P60), .VPER_50(P50)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .border_en(border_en), .line_stb(line_stb), .frame_stb(frame_stb),
        .field_odd(field_odd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_cfg();
        wr(0, eH); wr(1, ehbb); wr(2, ehbe); wr(3, ehdb | (ehalf_flag << 9));
        wr(4, ehde); wr(5, ehss); wr(6, evbb); wr(7, evbe); wr(8, evdb);
        wr(9, evde); wr(10, evss);
        wr(11, ehpol | (evpol << 1) | (eil << 2) | (eds << 3) | (er50 << 4));
    endtask

    task automatic sync_frame();
        @(negedge clk);
        while (!frame_stb) @(negedge clk);
        @(posedge clk);
    endtask

    // Check whole frames cycle by cycle; optionally write HPER=inj_val at cycle inj_t.
    task automatic check_frames(input int nfr, input int inj_t, input int inj_val);
        int hp, half, step, lines, vper, odd, ncyc;
        bit pend;
        hp = eH + 1;
        half = hp / 2;
        step = eds ? 1 : 2;
        vper = er50 ? P50 : P60;
        lines = vper / step + 1;
        ncyc = lines * hp;
        odd = -1;
        pend = 0;
        for (int f = 0; f < nfr; f++) begin
            for (int t = 0; t < ncyc; t++) begin
                int h, ln, v, hdbe, hd, vd, ed, eb, hsa, vsa;
                @(negedge clk);
                if (pend) begin wr_en = 1'b0; pend = 0; end
                h = t % hp; ln = t / hp; v = ln * step;
                if (t == 0) begin
                    if (odd >= 0) chk("R6", "field toggle", int'(field_odd), 1 - odd);
                    odd = int'(field_odd);
                end
                hdbe = ehdb + (ehalf_flag ? half : 0);
                hd = (h >= hdbe && h < ehde) ? 1 : 0;
                vd = (v >= evdb && v < evde) ? 1 : 0;
                ed = hd & vd;
                eb = (h >= ehbb && h < ehbe && v >= evbb && v < evbe && !ed) ? 1 : 0;
                hsa = (h >= ehss) ? 1 : 0;
                if (eil && odd == 1) vsa = (v > evss || (v == evss && h >= half)) ? 1 : 0;
                else vsa = (v >= evss) ? 1 : 0;
                chk("R1", "line_stb", int'(line_stb), (h == eH) ? 1 : 0);
                chk("R2", "frame_stb", int'(frame_stb), (h == eH && ln == lines - 1) ? 1 : 0);
                chk("R3", "disp_en", int'(disp_en), ed);
                chk("R4", "border_en", int'(border_en), eb);
                chk("R5", "hsync", int'(hsync), ehpol ? hsa : 1 - hsa);
                chk("R6", "vsync", int'(vsync), evpol ? vsa : 1 - vsa);
                chk("R6", "field_odd", int'(field_odd), odd);
                if (f == 0 && t == inj_t) begin
                    // R7: mid-frame write must not disturb this frame
                    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 16'(inj_val);
                    pend = 1;
                end
            end
            @(posedge clk);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state with all settings zero
        chk("R8", "line_stb in reset", int'(line_stb), 1);
        chk("R8", "disp_en in reset", int'(disp_en), 0);
        chk("R8", "border_en in reset", int'(border_en), 0);
        chk("R8", "hsync in reset", int'(hsync), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "line_stb after reset", int'(line_stb), 1);
        chk("R8", "disp_en after reset", int'(disp_en), 0);

        // Config A: single-step lines, 60 Hz preset, positive hsync (R9 map)
        eH = 19; ehbb = 1; ehbe = 18; ehdb = 4; ehalf_flag = 0; ehde = 16; ehss = 17;
        evbb = 2; evbe = 36; evdb = 6; evde = 30; evss = 34;
        ehpol = 1; evpol = 0; eil = 0; eds = 0; er50 = 0;
        load_cfg();
        sync_frame();
        check_frames(1, 100, 13);

        // R7: the mid-frame HPER write applies only from the next frame
        eH = 13;
        check_frames(1, -1, 0);

        // Config B: double scan, interlace, half-line display, 50 Hz preset, swapped polarity
        eH = 15; ehbb = 0; ehbe = 15; ehdb = 2; ehalf_flag = 1; ehde = 14; ehss = 12;
        evbb = 1; evbe = 48; evdb = 5; evde = 40; evss = 45;
        ehpol = 0; evpol = 1; eil = 1; eds = 1; er50 = 1;
        load_cfg();
        sync_frame();
        check_frames(2, -1, 0);

        // Config C: odd horizontal period, interlace with single-step lines
        eH = 10; ehbb = 2; ehbe = 9; ehdb = 1; ehalf_flag = 1; ehde = 10; ehss = 8;
        evbb = 0; evbe = 39; evdb = 3; evde = 33; evss = 35;
        ehpol = 1; evpol = 1; eil = 1; eds = 0; er50 = 0;
        load_cfg();
        sync_frame();
        check_frames(2, -1, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule